// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the software-visible register file of an interrupt distributor. A 32-bit memory-mapped bus with a 12-bit byte address, write data, byte strobes and a registered read port gives access to a global control register, a read-only type register, a constant identification register, and per-interrupt banks. The banks hold enable, pending, active, priority, processor-target and trigger configuration state. The number of interrupt lines is set by a parameter, in groups of 32. IDs 0 to 31 are always the software-generated (0–15) and private (16–31) interrupts. Shared interrupts start at ID 32.

Arbitration, CPU signalling and edge/level detection live elsewhere. Those neighbours see this block through flat vectors: enable, pending, priority, target and edge-select outputs, plus a hardware pending-set pulse input and an active-state input.

Top module: `irq_dist_regs`

## Requirements
- R1: After synchronous reset, the control register, all enable and pending bits, all priority and target fields, all shared-interrupt edge selects, and `rdata` are zero.
- R2: A read issued with `rd_en` returns its data on `rdata` after the next rising edge, showing the state that existed before any write in the same cycle. In a cycle after one without `rd_en`, `rdata` is zero.
- R3: Offset 0x000 stores only bit 0 (the distributor enable, driven on `dist_en`); bits 31:1 read zero. Offset 0x004 reads `CPU_COUNT-1` in bits 7:5 and `LINE_GROUPS-1` in bits 4:0, with all other bits zero. Offset 0x008 reads 0x0300043B. Writes to 0x004 and 0x008 are ignored.
- R4: Word i of the set-enable bank (0x100 + 4i) and of the clear-enable bank (0x180 + 4i) covers IDs 32i to 32i+31, with bit b mapping to ID 32i+b. Writing 1 sets (set bank) or clears (clear bank) the enable bit. Writing 0 has no effect. Both banks read the current enable state, which is also driven on `irq_enable`.
- R5: The set-pending (0x200) and clear-pending (0x280) banks follow the same layout and rules, with the state driven on `irq_pending`. A `pend_set` bit sets its pending bit only while `dist_en` is 1. When a hardware set and a software clear hit the same bit in one cycle, the set wins.
- R6: The active bank at 0x300 reads `irq_active` with the same layout as R4. Writes to it are ignored.
- R7: The priority bank at 0x400 holds one byte per ID: byte n (bits 8n+7:8n) of word i belongs to ID 4i+n. Only bits 7:4 of each byte are stored, and bits 3:0 read zero. Each write updates only the lanes whose `wstrb` bit is set. The stored nibble of ID k is driven on `irq_prio[4k+3:4k]`.
- R8: The target bank at 0x800 uses the same byte layout and strobe rule. Only the low `CPU_COUNT` bits of each byte are stored, and with `CPU_COUNT` = 1 the whole bank reads zero. The byte of ID k is driven on `irq_target[8k+7:8k]`.
- R9: Outside the priority and target banks, a write whose `wstrb` is not 4'b1111 has no effect.
- R10: In the configuration bank at 0xC00, word j covers IDs 16j to 16j+15, and ID 16j+k uses bits 2k+1:2k. IDs 0–15 read 0b10 and IDs 16–31 read 0b01. For shared IDs the low bit reads 1 and the high bit is writable, where 1 selects edge and 0 selects level. `irq_edge[k]` carries the high bit for every ID.
- R11: Reserved offsets, and bank words for IDs at or above 32×`LINE_GROUPS`, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 12 | Byte address within the register page |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte lane strobes for writes |
| rdata | output | 32 | Registered read data |
| dist_en | output | 1 | Distributor enable (control bit 0) |
| pend_set | input | 32×LINE_GROUPS | Hardware pending-set pulses per ID |
| irq_active | input | 32×LINE_GROUPS | Active state per ID from the CPU side |
| irq_enable | output | 32×LINE_GROUPS | Enable state per ID |
| irq_pending | output | 32×LINE_GROUPS | Pending state per ID |
| irq_prio | output | 128×LINE_GROUPS | Stored 4-bit priority per ID |
| irq_target | output | 256×LINE_GROUPS | Target byte per ID |
| irq_edge | output | 32×LINE_GROUPS | Edge-select per ID |

## Verification
The assertions check the following on every cycle: the idle-zero read path, that enable, pending and priority state cannot move without a bus write, that pending cannot move while the distributor is disabled, that hardware set pulses take effect while it is enabled, and that type, control and reserved reads return their fixed patterns. The bench scenarios cover the rest: the set/clear pairing across every implemented word, the byte-lane merging and nibble masking of the priority and target banks, the fixed and writable bit-pairs of the configuration bank, strobe rejection on word-only registers, and the set-over-clear collision.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam logic [31:0] IDENT_VALUE = 32'h0300_043B;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_IDENT,
    RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD, RG_ACTIVE,
    RG_PRIO, RG_TARGET, RG_CFG
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [7:0] widx;
  } decode_t;

  // Map a byte address to a register region and word index; words past
  // the implemented range collapse to RG_NONE.
  function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                          input int unsigned bit_words,
                                          input int unsigned byte_words,
                                          input int unsigned cfg_words);
    decode_t d;
    logic    ok;
    d.region = RG_NONE;
    d.widx   = '0;
    ok       = 1'b0;
    if (a[11:2] == 10'd0) begin
      d.region = RG_CTRL;  ok = 1'b1;
    end else if (a[11:2] == 10'd1) begin
      d.region = RG_TYPE;  ok = 1'b1;
    end else if (a[11:2] == 10'd2) begin
      d.region = RG_IDENT; ok = 1'b1;
    end else if (a[11:10] == 2'b00 && a[9:7] >= 3'd2 && a[9:7] <= 3'd6) begin
      case (a[9:7])
        3'd2:    d.region = RG_SETEN;
        3'd3:    d.region = RG_CLREN;
        3'd4:    d.region = RG_SETPD;
        3'd5:    d.region = RG_CLRPD;
        default: d.region = RG_ACTIVE;
      endcase
      d.widx = {3'b000, a[6:2]};
      ok     = 32'(a[6:2]) < bit_words;
    end else if (a[11:10] == 2'b01) begin
      d.region = RG_PRIO;
      d.widx   = a[9:2];
      ok       = 32'(a[9:2]) < byte_words;
    end else if (a[11:10] == 2'b10) begin
      d.region = RG_TARGET;
      d.widx   = a[9:2];
      ok       = 32'(a[9:2]) < byte_words;
    end else if (a[11:8] == 4'hC) begin
      d.region = RG_CFG;
      d.widx   = {2'b00, a[7:2]};
      ok       = 32'(a[7:2]) < cfg_words;
    end
    if (!ok) d.region = RG_NONE;
    return d;
  endfunction

endpackage

// File: rtl/irq_dist_bitbank.sv
// One state bit per interrupt, updated through a write-1-to-set port,
// a write-1-to-clear port and a hardware set vector (set has priority).
module irq_dist_bitbank #(
  parameter int unsigned WORDS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_we,
  input  logic                  clr_we,
  input  logic [7:0]            widx,
  input  logic [31:0]           wdata,
  input  logic [WORDS*32-1:0]   hw_set,
  output logic [WORDS*32-1:0]   state_o
);

  logic [31:0] st [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] nxt;
    logic        hit;

    assign hit = (widx == 8'(w));

    always_comb begin
      nxt = st[w];
      if (set_we && hit) nxt = nxt | wdata;
      if (clr_we && hit) nxt = nxt & ~wdata;
      nxt = nxt | hw_set[w*32 +: 32];
    end

    always_ff @(posedge clk) begin
      if (rst) st[w] <= '0;
      else     st[w] <= nxt;
    end

    assign state_o[w*32 +: 32] = st[w];
  end

endmodule

// File: rtl/irq_dist_bytebank.sv
// One byte per interrupt, byte-lane writable, with a per-lane keep mask.
module irq_dist_bytebank #(
  parameter int unsigned WORDS     = 16,
  parameter logic [7:0]  LANE_MASK = 8'hF0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [7:0]            widx,
  input  logic [31:0]           wdata,
  input  logic [3:0]            wstrb,
  output logic [WORDS*32-1:0]   fields_o
);

  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]   mem [WORDS];
  logic [IW-1:0] wi;

  assign wi = widx[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < 4; l++) begin
        if (wstrb[l]) mem[wi][8*l +: 8] <= wdata[8*l +: 8] & LANE_MASK;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign fields_o[w*32 +: 32] = mem[w];
  end

endmodule

// File: rtl/irq_dist_cfgbank.sv
// Trigger selection: fixed for IDs 0..31, one writable edge bit per shared ID.
module irq_dist_cfgbank #(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [7:0]           widx,
  input  logic [31:0]          wdata,
  output logic [NUM_IRQ-1:0]   edge_o,
  output logic [2*NUM_IRQ-1:0] pairs_o
);

  for (genvar id = 0; id < NUM_IRQ; id++) begin : g_id
    if (id < 16) begin : g_sgi
      assign edge_o[id] = 1'b1;
    end else if (id < 32) begin : g_ppi
      assign edge_o[id] = 1'b0;
    end else begin : g_spi
      logic edge_q;
      always_ff @(posedge clk) begin
        if (rst)                             edge_q <= 1'b0;
        else if (we && widx == 8'(id / 16))  edge_q <= wdata[2*(id % 16) + 1];
      end
      assign edge_o[id] = edge_q;
    end
    assign pairs_o[2*id]     = (id >= 16);
    assign pairs_o[2*id + 1] = edge_o[id];
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned LINE_GROUPS = 2,
  parameter int unsigned CPU_COUNT   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [11:0]                   addr,
  input  logic [31:0]                   wdata,
  input  logic [3:0]                    wstrb,
  output logic [31:0]                   rdata,
  output logic                          dist_en,
  input  logic [32*LINE_GROUPS-1:0]     pend_set,
  input  logic [32*LINE_GROUPS-1:0]     irq_active,
  output logic [32*LINE_GROUPS-1:0]     irq_enable,
  output logic [32*LINE_GROUPS-1:0]     irq_pending,
  output logic [128*LINE_GROUPS-1:0]    irq_prio,
  output logic [256*LINE_GROUPS-1:0]    irq_target,
  output logic [32*LINE_GROUPS-1:0]     irq_edge
);

  localparam int unsigned NUM_IRQ    = 32 * LINE_GROUPS;
  localparam int unsigned BIT_WORDS  = LINE_GROUPS;
  localparam int unsigned BYTE_WORDS = NUM_IRQ / 4;
  localparam int unsigned CFG_WORDS  = NUM_IRQ / 16;
  localparam logic [7:0]  PRIO_MASK  = 8'hF0;
  localparam logic [7:0]  TGT_MASK   = (CPU_COUNT > 1) ? 8'((1 << CPU_COUNT) - 1) : 8'h00;
  localparam logic [31:0] TYPE_VALUE = {24'b0, 3'(CPU_COUNT - 1), 5'(LINE_GROUPS - 1)};

  decode_t dec;
  logic    word_wr;
  logic [NUM_IRQ*8-1:0] prio_flat;
  logic [2*NUM_IRQ-1:0] cfg_flat;
  logic [31:0]          rd_word;
  logic [12:0]          bit_base;
  logic [12:0]          wide_base;

  assign dec     = decode_addr(addr, BIT_WORDS, BYTE_WORDS, CFG_WORDS);
  assign word_wr = wr_en && (wstrb == 4'hF);

  // Control register: only the enable bit is kept.
  always_ff @(posedge clk) begin
    if (rst)                                 dist_en <= 1'b0;
    else if (word_wr && dec.region == RG_CTRL) dist_en <= wdata[0];
  end

  irq_dist_bitbank #(.WORDS(BIT_WORDS)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_we (word_wr && dec.region == RG_SETEN),
    .clr_we (word_wr && dec.region == RG_CLREN),
    .widx   (dec.widx),
    .wdata  (wdata),
    .hw_set ({NUM_IRQ{1'b0}}),
    .state_o(irq_enable)
  );

  irq_dist_bitbank #(.WORDS(BIT_WORDS)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .set_we (word_wr && dec.region == RG_SETPD),
    .clr_we (word_wr && dec.region == RG_CLRPD),
    .widx   (dec.widx),
    .wdata  (wdata),
    .hw_set (dist_en ? pend_set : {NUM_IRQ{1'b0}}),
    .state_o(irq_pending)
  );

  irq_dist_bytebank #(.WORDS(BYTE_WORDS), .LANE_MASK(PRIO_MASK)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en && dec.region == RG_PRIO),
    .widx    (dec.widx),
    .wdata   (wdata),
    .wstrb   (wstrb),
    .fields_o(prio_flat)
  );

  irq_dist_bytebank #(.WORDS(BYTE_WORDS), .LANE_MASK(TGT_MASK)) u_target (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en && dec.region == RG_TARGET),
    .widx    (dec.widx),
    .wdata   (wdata),
    .wstrb   (wstrb),
    .fields_o(irq_target)
  );

  irq_dist_cfgbank #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (word_wr && dec.region == RG_CFG),
    .widx   (dec.widx),
    .wdata  (wdata),
    .edge_o (irq_edge),
    .pairs_o(cfg_flat)
  );

  for (genvar id = 0; id < NUM_IRQ; id++) begin : g_prio_out
    assign irq_prio[4*id +: 4] = prio_flat[8*id + 4 +: 4];
  end

  assign bit_base  = {dec.widx, 5'b0};
  assign wide_base = {dec.widx, 5'b0};

  always_comb begin
    rd_word = '0;
    case (dec.region)
      RG_CTRL:             rd_word = {31'b0, dist_en};
      RG_TYPE:             rd_word = TYPE_VALUE;
      RG_IDENT:            rd_word = IDENT_VALUE;
      RG_SETEN, RG_CLREN:  rd_word = irq_enable[bit_base +: 32];
      RG_SETPD, RG_CLRPD:  rd_word = irq_pending[bit_base +: 32];
      RG_ACTIVE:           rd_word = irq_active[bit_base +: 32];
      RG_PRIO:             rd_word = prio_flat[wide_base +: 32];
      RG_TARGET:           rd_word = irq_target[wide_base +: 32];
      RG_CFG:              rd_word = cfg_flat[wide_base +: 32];
      default:             rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_word : 32'h0;
  end

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int unsigned LINE_GROUPS = 2,
  parameter int unsigned CPU_COUNT   = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [11:0]                 addr,
  input logic [3:0]                  wstrb,
  input logic [31:0]                 rdata,
  input logic                        dist_en,
  input logic [32*LINE_GROUPS-1:0]   pend_set,
  input logic [32*LINE_GROUPS-1:0]   irq_enable,
  input logic [32*LINE_GROUPS-1:0]   irq_pending,
  input logic [128*LINE_GROUPS-1:0]  irq_prio
);

  localparam logic [31:0] TYPE_EXP = {24'b0, 3'(CPU_COUNT - 1), 5'(LINE_GROUPS - 1)};

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == 32'h0); // R2

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 12'h000) |=> rdata[31:1] == 31'h0); // R3

  AST_TYPE_VALUE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 12'h004) |=> rdata == TYPE_EXP); // R3

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(irq_enable)); // R4

  AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!dist_en && !wr_en) |=> $stable(irq_pending)); // R5

  AST_PEND_HW_SET: assert property (@(posedge clk) disable iff (rst)
    (dist_en && !wr_en) |=> ((irq_pending & $past(pend_set)) == $past(pend_set))); // R5

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(irq_prio)); // R7

  AST_CTRL_STROBE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wstrb != 4'hF && addr == 12'h000) |=> $stable(dist_en)); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 12'h00C && addr < 12'h100) |=> rdata == 32'h0); // R11

endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .LINE_GROUPS(LINE_GROUPS),
  .CPU_COUNT  (CPU_COUNT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wstrb      (wstrb),
  .rdata      (rdata),
  .dist_en    (dist_en),
  .pend_set   (pend_set),
  .irq_enable (irq_enable),
  .irq_pending(irq_pending),
  .irq_prio   (irq_prio)
);

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;

  localparam int unsigned LG   = 2;
  localparam int unsigned CPUS = 2;
  localparam int unsigned NI   = 32 * LG;
  localparam int unsigned BW   = NI / 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [3:0]        wstrb = '0;
  logic [31:0]       rdata;
  logic              dist_en;
  logic [NI-1:0]     pend_set = '0, irq_active = '0;
  logic [NI-1:0]     irq_enable, irq_pending, irq_edge;
  logic [NI*4-1:0]   irq_prio;
  logic [NI*8-1:0]   irq_target;

  irq_dist_regs #(.LINE_GROUPS(LG), .CPU_COUNT(CPUS)) i_irq_dist_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .dist_en(dist_en),
    .pend_set(pend_set), .irq_active(irq_active), .irq_enable(irq_enable),
    .irq_pending(irq_pending), .irq_prio(irq_prio), .irq_target(irq_target),
    .irq_edge(irq_edge)
  );

  int checks = 0, errors = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    wr_en = 1'b0; wstrb = 4'h0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  logic [31:0] en_m [LG];
  logic [31:0] pm [BW];
  logic [31:0] tm [BW];
  logic [31:0] pats [4] = '{32'hFFFF_0000, 32'h0F0F_A5A5, 32'h8000_0001, 32'h1234_5678};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 pending lo", irq_pending[31:0], 32'h0);
    check("R1 pending hi", irq_pending[63:32], 32'h0);
    rchk("R1 ctrl", 12'h000, 32'h0);
    rchk("R1 seten", 12'h104, 32'h0);
    rchk("R1 setpd", 12'h200, 32'h0);
    rchk("R1 prio", 12'h41C, 32'h0);
    rchk("R1 target", 12'h800, 32'h0);

    // R2 idle read path returns zero
    @(negedge clk);
    check("R2 idle", rdata, 32'h0);

    // R3 type and identification
    rchk("R3 type", 12'h004, 32'((CPUS - 1) << 5) | 32'(LG - 1));
    rchk("R3 ident", 12'h008, 32'h0300_043B);
    wr(12'h008, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    rchk("R3 ident ro", 12'h008, 32'h0300_043B);
    rchk("R3 type ro", 12'h004, 32'h21);
    wr(12'h000, 32'hFFFF_FFFF);
    rchk("R3 ctrl bit0", 12'h000, 32'h1);
    check("R3 dist_en", 32'(dist_en), 32'h1);
    wr(12'h000, 32'h0, 4'h1);
    rchk("R9 ctrl strobe", 12'h000, 32'h1);

    // R4 enable set/clear sweep
    for (int w = 0; w < LG; w++) begin
      en_m[w] = '0;
      for (int p = 0; p < 4; p++) begin
        logic [31:0] c;
        c = {pats[p][15:0], pats[p][31:16]};
        wr(12'h100 + 12'(4*w), pats[p]);
        en_m[w] = en_m[w] | pats[p];
        rchk("R4 set read", 12'h100 + 12'(4*w), en_m[w]);
        wr(12'h180 + 12'(4*w), c);
        en_m[w] = en_m[w] & ~c;
        rchk("R4 clr read", 12'h180 + 12'(4*w), en_m[w]);
        check("R4 port", irq_enable[32*w +: 32], en_m[w]);
      end
      wr(12'h100 + 12'(4*w), 32'h0);
      wr(12'h180 + 12'(4*w), 32'h0);
      rchk("R4 zero no effect", 12'h100 + 12'(4*w), en_m[w]);
    end
    wr(12'h100, 32'hFFFF_FFFF, 4'h3);
    rchk("R9 enable strobe", 12'h100, en_m[0]);
    wr(12'h108, 32'hFFFF_FFFF);
    rchk("R11 seten beyond", 12'h108, 32'h0);
    rchk("R11 clren beyond", 12'h188, 32'h0);

    // R5 pending
    wr(12'h200, 32'h0000_00F0);
    rchk("R5 set", 12'h200, 32'h0000_00F0);
    wr(12'h280, 32'h0000_0030);
    rchk("R5 clr", 12'h280, 32'h0000_00C0);
    @(negedge clk); pend_set[40] = 1'b1;
    @(negedge clk); pend_set = '0;
    rchk("R5 hw set enabled", 12'h204, 32'h0000_0100);
    wr(12'h000, 32'h0);
    @(negedge clk); pend_set[41] = 1'b1;
    @(negedge clk); pend_set = '0;
    rchk("R5 hw set disabled", 12'h204, 32'h0000_0100);
    wr(12'h000, 32'h1);
    @(negedge clk);
    pend_set[1] = 1'b1; wr_en = 1'b1; addr = 12'h280; wdata = 32'h2; wstrb = 4'hF;
    @(negedge clk);
    pend_set = '0; wr_en = 1'b0; wstrb = 4'h0;
    rchk("R5 set beats clear", 12'h200, 32'h0000_00C2);
    check("R5 port", irq_pending[31:0], 32'h0000_00C2);

    // R6 active
    irq_active = 64'hDEAD_BEEF_0123_4567;
    rchk("R6 active lo", 12'h300, 32'h0123_4567);
    rchk("R6 active hi", 12'h304, 32'hDEAD_BEEF);
    wr(12'h300, 32'h0);
    rchk("R6 write ignored", 12'h300, 32'h0123_4567);
    rchk("R11 active beyond", 12'h308, 32'h0);

    // R7/R8 priority and target: word writes then per-lane writes
    for (int i = 0; i < BW; i++) begin
      logic [31:0] d;
      d = 32'(32'h9E37_79B9 * (i + 1));
      wr(12'h400 + 12'(4*i), d);
      wr(12'h800 + 12'(4*i), d);
      pm[i] = d & 32'hF0F0_F0F0;
      tm[i] = d & 32'h0303_0303;
    end
    for (int i = 0; i < BW; i++) begin
      for (int l = 0; l < 4; l++) begin
        logic [31:0] d;
        d = 32'(32'h7F4A_7C15 * (i * 4 + l + 3));
        wr(12'h400 + 12'(4*i), d, 4'(1 << l));
        wr(12'h800 + 12'(4*i), d, 4'(1 << l));
        pm[i][8*l +: 8] = d[8*l +: 8] & 8'hF0;
        tm[i][8*l +: 8] = d[8*l +: 8] & 8'h03;
      end
    end
    for (int i = 0; i < BW; i++) begin
      rchk("R7 prio word", 12'h400 + 12'(4*i), pm[i]);
      rchk("R8 target word", 12'h800 + 12'(4*i), tm[i]);
    end
    for (int id = 0; id < NI; id++) begin
      check("R7 prio port", 32'(irq_prio[4*id +: 4]), 32'(pm[id/4][8*(id%4) + 4 +: 4]));
      check("R8 target port", 32'(irq_target[8*id +: 8]), 32'(tm[id/4][8*(id%4) +: 8]));
    end
    wr(12'h440, 32'hFFFF_FFFF);
    rchk("R11 prio beyond", 12'h440, 32'h0);
    rchk("R11 target beyond", 12'h840, 32'h0);

    // R10 configuration
    rchk("R10 sgi", 12'hC00, 32'hAAAA_AAAA);
    rchk("R10 ppi", 12'hC04, 32'h5555_5555);
    rchk("R10 spi reset", 12'hC08, 32'h5555_5555);
    for (int j = 0; j < 4; j++) wr(12'hC00 + 12'(4*j), 32'hFFFF_FFFF);
    rchk("R10 sgi fixed", 12'hC00, 32'hAAAA_AAAA);
    rchk("R10 ppi fixed", 12'hC04, 32'h5555_5555);
    rchk("R10 spi edge a", 12'hC08, 32'hFFFF_FFFF);
    rchk("R10 spi edge b", 12'hC0C, 32'hFFFF_FFFF);
    check("R10 edge port lo", irq_edge[31:0], 32'h0000_FFFF);
    check("R10 edge port hi", irq_edge[63:32], 32'hFFFF_FFFF);
    wr(12'hC08, 32'h0, 4'h1);
    rchk("R9 cfg strobe", 12'hC08, 32'hFFFF_FFFF);
    wr(12'hC08, 32'h0000_000F);
    rchk("R10 spi mixed", 12'hC08, 32'h5555_555F);
    check("R10 edge port mixed", irq_edge[63:32], 32'hFFFF_0003);
    rchk("R11 cfg beyond", 12'hC10, 32'h0);

    // R11 reserved offsets
    wr(12'hF00, 32'hFFFF_FFFF);
    rchk("R11 reserved F00", 12'hF00, 32'h0);
    rchk("R11 reserved 00C", 12'h00C, 32'h0);
    rchk("R11 reserved 380", 12'h380, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule